// File: doc/BRIEF.md
# Register Rename Map Unit

This unit renames one decoded instruction per cycle, translating its logical register indices onto a larger physical register file. Each instruction presents two logical source indices, a logical destination index and a flag saying whether the destination is written. The unit answers in the same cycle with the physical tags currently bound to both sources. It also returns a fresh physical tag for the destination and the physical tag that destination was bound to until now. That old tag lets downstream retirement logic give it back later.

Internally the unit keeps a table from logical to physical registers and a circular FIFO of unused physical registers. A destination always takes the register at the FIFO head. Registers handed back on the release port go in at the FIFO tail. The table is read for the sources before the same instruction's destination overwrites it, so an instruction that reads and writes the same logical register sees the older binding. Every later instruction sees the new one. When no physical register is free, an instruction with a destination is held off. An instruction without a destination still passes.

Top module: `reg_rename_map`

## Requirements
- R1: After reset, logical register i is bound to physical register i, for every logical register.
- R2: The source outputs return the current table entry of each logical source index, read before the same instruction's destination is rebound, so reading and writing r3 in one instruction returns the old tag of r3 on the source.
- R3: An accepted instruction with a destination receives the physical tag at the FIFO head. After reset, the FIFO holds tags NLOG through NPHYS-1 in increasing order.
- R4: After an accepted instruction rebinds a logical register, any later instruction reading that register receives the new tag.
- R5: Back-to-back writes to r1, r2 and r1 receive three distinct tags in FIFO order, and the second write to r1 reports the first write's tag as its old binding.
- R6: The old-tag output equals the table entry of the logical destination before the instruction is accepted.
- R7: With the FIFO empty and a destination requested, ready is low, and the table and the FIFO are left unchanged.
- R8: An instruction without a destination is accepted even when the FIFO is empty, and it consumes no FIFO entry.
- R9: Tags returned on the release port are handed out again after the tags already in the FIFO, in the order they were returned.
- R10: While in_valid is low, no tag is consumed and the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented for renaming |
| src_a | input | $clog2(NLOG) | Logical index of the first source |
| src_b | input | $clog2(NLOG) | Logical index of the second source |
| dst | input | $clog2(NLOG) | Logical index of the destination |
| dst_valid | input | 1 | The instruction writes dst |
| ready | output | 1 | The presented instruction can be accepted this cycle |
| phys_a | output | $clog2(NPHYS) | Physical tag of the first source |
| phys_b | output | $clog2(NPHYS) | Physical tag of the second source |
| phys_dst | output | $clog2(NPHYS) | Physical tag offered for the destination (FIFO head) |
| old_dst | output | $clog2(NPHYS) | Physical tag bound to dst before renaming |
| free_valid | input | 1 | A physical register is being returned |
| free_tag | input | $clog2(NPHYS) | Physical register being returned |

## Verification
Directed sequences cover the cases that a simple pass-through or a single-tag allocator would get wrong. These include identity reads after reset, an instruction that reads and writes the same register, and the r1/r2/r1 write pattern. They also include draining the FIFO to empty, which separates a stall on a destination from a pass of an instruction with no destination. Returned tags are recycled to confirm FIFO order at the tail. A long random phase then mixes sources, destinations, idle cycles and releases of old tags. A bench reference table and a queue predict every tag, so any lost, duplicated or reordered tag shows up as a mismatch.

// File: rtl/reg_rename_map.sv
module reg_rename_map #(
  parameter int NLOG  = 8,
  parameter int NPHYS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [$clog2(NLOG)-1:0]    src_a,
  input  logic [$clog2(NLOG)-1:0]    src_b,
  input  logic [$clog2(NLOG)-1:0]    dst,
  input  logic                       dst_valid,
  output logic                       ready,
  output logic [$clog2(NPHYS)-1:0]   phys_a,
  output logic [$clog2(NPHYS)-1:0]   phys_b,
  output logic [$clog2(NPHYS)-1:0]   phys_dst,
  output logic [$clog2(NPHYS)-1:0]   old_dst,
  input  logic                       free_valid,
  input  logic [$clog2(NPHYS)-1:0]   free_tag
);
  localparam int PW = $clog2(NPHYS);
  localparam int CW = $clog2(NPHYS + 1);
  localparam int NFREE = NPHYS - NLOG;

  logic [NLOG-1:0][PW-1:0]  map_q;
  logic [NPHYS-1:0][PW-1:0] fifo_q;
  logic [PW-1:0]            head_q, tail_q;
  logic [CW-1:0]            count_q;
  logic                     alloc;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(NPHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign ready    = !(dst_valid && count_q == '0);
  assign alloc    = in_valid && ready && dst_valid;
  assign phys_a   = map_q[src_a];
  assign phys_b   = map_q[src_b];
  assign old_dst  = map_q[dst];
  assign phys_dst = fifo_q[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOG; i++) map_q[i] <= PW'(i);
      for (int k = 0; k < NPHYS; k++) fifo_q[k] <= (k < NFREE) ? PW'(NLOG + k) : '0;
      head_q  <= '0;
      tail_q  <= PW'(NFREE % NPHYS);
      count_q <= CW'(NFREE);
    end else begin
      if (alloc) begin
        map_q[dst] <= phys_dst;
        head_q     <= wrap_inc(head_q);
      end
      if (free_valid) begin
        fifo_q[tail_q] <= free_tag;
        tail_q         <= wrap_inc(tail_q);
      end
      count_q <= count_q + CW'(free_valid) - CW'(alloc);
    end
  end

  p_new_tag_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (!in_valid || src_a != $past(dst) || phys_a == $past(phys_dst)));

  p_stall_holds_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ready) |=> $stable(map_q));

  p_pop_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !free_valid) |=> count_q == $past(count_q) - 1'b1);

  p_distinct_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> phys_dst != old_dst);

  p_idle_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !free_valid) |=> ($stable(map_q) && $stable(count_q)));

  always_ff @(posedge clk)
    if (rst_n) p_no_overflow_r9: assert (count_q <= CW'(NPHYS));
endmodule

// File: tb/tb_reg_rename_map.sv
module tb_reg_rename_map;
  localparam int CLK_PERIOD = 10;
  localparam int NLOG = 8;
  localparam int NPHYS = 16;
  localparam int LW = $clog2(NLOG);
  localparam int PW = $clog2(NPHYS);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, dst_valid = 0, free_valid = 0;
  logic [LW-1:0] src_a = 0, src_b = 0, dst = 0;
  logic [PW-1:0] free_tag = 0;
  logic ready;
  logic [PW-1:0] phys_a, phys_b, phys_dst, old_dst;

  reg_rename_map #(.NLOG(NLOG), .NPHYS(NPHYS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .dst(dst), .dst_valid(dst_valid), .ready(ready), .phys_a(phys_a), .phys_b(phys_b),
    .phys_dst(phys_dst), .old_dst(old_dst), .free_valid(free_valid), .free_tag(free_tag));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int mdl_map [NLOG];
  int fq[$];
  int pool[$];
  int got_a, got_b, got_d, got_o, got_r;
  bit done = 0;

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void drop_pool(input int t);
    for (int i = 0; i < pool.size(); i++)
      if (pool[i] == t) begin pool.delete(i); return; end
  endfunction

  task automatic step(input bit iv, input int sa, input int sb, input int d,
                      input bit dv, input bit cv, input int ct);
    bit er;
    @(negedge clk);
    in_valid = iv; src_a = LW'(sa); src_b = LW'(sb); dst = LW'(d); dst_valid = dv;
    free_valid = cv; free_tag = PW'(ct);
    #1;
    got_a = phys_a; got_b = phys_b; got_d = phys_dst; got_o = old_dst; got_r = ready;
    er = !(dv && fq.size() == 0);
    chk(got_r, er, "R7 ready");
    chk(got_a, mdl_map[sa], "R2 phys_a");
    chk(got_b, mdl_map[sb], "R2 phys_b");
    chk(got_o, mdl_map[d], "R6 old_dst");
    if (dv && er) chk(got_d, fq[0], "R3 phys_dst");
    if (iv && er && dv) begin
      pool.push_back(mdl_map[d]);
      mdl_map[d] = fq.pop_front();
    end
    if (cv) fq.push_back(ct);
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NLOG; i++) mdl_map[i] = i;
    for (int k = NLOG; k < NPHYS; k++) fq.push_back(k);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: identity map after reset
    for (int i = 0; i < NLOG; i++) begin
      step(0, i, NLOG-1-i, 0, 0, 0, 0);
      chk(got_a, i, "R1 reset map a");
      chk(got_b, NLOG-1-i, "R1 reset map b");
    end
    // R10: idle cycle does not consume
    step(0, 0, 0, 3, 1, 0, 0);
    chk(got_d, NLOG, "R10 idle head");
    step(0, 3, 0, 3, 1, 0, 0);
    chk(got_d, NLOG, "R10 head unchanged");
    chk(got_a, 3, "R10 map unchanged");
    // R2: read-before-write on r3
    step(1, 3, 3, 3, 1, 0, 0);
    chk(got_a, 3, "R2 same-instr source");
    chk(got_d, NLOG, "R3 first alloc");
    chk(got_o, 3, "R6 old r3");
    // R4
    step(1, 3, 0, 0, 0, 0, 0);
    chk(got_a, NLOG, "R4 new r3 tag");
    // R5: r1, r2, r1
    step(1, 0, 0, 1, 1, 0, 0); chk(got_d, NLOG+1, "R5 w1 r1");
    step(1, 0, 0, 2, 1, 0, 0); chk(got_d, NLOG+2, "R5 w2 r2");
    step(1, 1, 0, 1, 1, 0, 0);
    chk(got_d, NLOG+3, "R5 w3 r1");
    chk(got_o, NLOG+1, "R5 old r1");
    chk(got_a, NLOG+1, "R5 source r1");
    // drain
    for (int d = 4; d < 8; d++) step(1, 0, 0, d, 1, 0, 0);
    // R7: empty stall
    step(1, 0, 1, 0, 1, 0, 0);
    chk(got_r, 0, "R7 stall on empty");
    // R8: no destination passes
    step(1, 0, 1, 0, 0, 0, 0);
    chk(got_r, 1, "R8 pass no dst");
    chk(got_a, 0, "R7 map kept r0");
    chk(got_b, NLOG+3, "R7 map kept r1");
    // R9: returned tags reused in order
    drop_pool(NLOG+1); drop_pool(2);
    step(0, 0, 0, 0, 0, 1, NLOG+1);
    step(0, 0, 0, 0, 0, 1, 2);
    step(1, 0, 0, 0, 1, 0, 0);
    chk(got_d, NLOG+1, "R9 first returned");
    step(1, 0, 0, 0, 1, 0, 0);
    chk(got_d, 2, "R9 second returned");
    chk(got_o, NLOG+1, "R9 old r0");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit cv; int ct;
      cv = 0; ct = 0;
      if (pool.size() > 0 && ($urandom % 3) == 0) begin
        int idx;
        idx = $urandom % pool.size();
        ct = pool[idx]; pool.delete(idx); cv = 1;
      end
      step(($urandom % 4) != 0, $urandom % NLOG, $urandom % NLOG,
           $urandom % NLOG, ($urandom % 4) != 0, cv, ct);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule